// File: doc/BRIEF.md
# ADC Conversion Control and Status Register

This block is the single 8-bit control and status register that sits between a processor bus and the sequencer of an analog-to-digital converter. Software uses it to choose a channel field, pick single or scan operation, start conversions and enable the end-of-conversion interrupt. The top bit is an end-of-conversion flag, and only hardware can set it. In single mode, every conversion-done pulse from the sequencer sets the flag. In scan mode, only the pulse that the sequencer marks as the last selected channel sets it.

Software clears the flag in two accesses. It must first read the register while the flag is 1, and then write a 0 to the flag bit. A write of 0 that has no such read before it does nothing to the flag. The flag also clears when a DMA transfer, started by the interrupt, reads the conversion data register. The interrupt request is the flag gated by the enable bit. A standby or module-stop input returns the whole register to zero, in the same way as reset.

Top module: `adc_ctl_reg`

## Requirements
- R1: After reset, and on the cycle after `stby_i` is high, the read data is 0x00 and `irq_o` is 0.
- R2: A write stores wdata bits 6..0, which are visible on the next cycle. Bit 6 is the interrupt enable, bit 5 drives `start_o`, bit 4 drives `scan_o`, and bits 3..0 drive `chan_o`.
- R3: Writing 1 to bit 7 never sets the flag and never clears it.
- R4: A write with bit 7 = 0 clears the flag if it is the first write after a read that returned bit 7 = 1.
- R5: A write with bit 7 = 0 and no arming read before it leaves the flag unchanged.
- R6: A high `dma_dread_i` clears the flag on the next cycle.
- R7: In single mode (bit 4 = 0), a `conv_done_i` pulse sets the flag on the next cycle, whatever the value of `conv_last_i`.
- R8: In scan mode (bit 4 = 1), a `conv_done_i` pulse sets the flag only when `conv_last_i` is high at the same time.
- R9: `irq_o` is 1 exactly when the flag and the enable bit 6 are both 1.
- R10: A set event wins over a software clear or a DMA clear in the same cycle.
- R11: Any write uses up an arming read, even a write of 1 to bit 7. The arming is also dropped whenever the flag clears. After either event, a later write of 0 does not clear the flag.
- R12: `bus_rdata_o` shows the live flag in bit 7 and the stored bits 6..0 in the same cycle, without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_i | input | 1 | Standby or module stop; clears the register synchronously |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data: flag plus the control bits |
| conv_done_i | input | 1 | One-cycle conversion-done pulse from the sequencer |
| conv_last_i | input | 1 | Marks the done pulse of the last channel in a scan |
| dma_dread_i | input | 1 | DMA read of the conversion data register |
| irq_o | output | 1 | End-of-conversion interrupt request |
| start_o | output | 1 | Start bit to the sequencer |
| scan_o | output | 1 | Scan mode select to the sequencer |
| chan_o | output | 4 | Channel select to the sequencer |

## Verification
The only result that is due in the same cycle as its stimulus is the read data. Every write, done pulse, DMA read or standby event shows up on the outputs exactly one clock edge later. The driver applies each stimulus just after a rising edge and holds it for one cycle. It then queues the expected outputs against the following idle cycle. The monitor compares those outputs at that cycle's falling edge, so each check sees the state produced by exactly one register update.

// File: rtl/adc_ctl_reg.sv
module adc_ctl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_i,
  input  logic       bus_rd_i,
  input  logic       bus_wr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  input  logic       conv_done_i,
  input  logic       conv_last_i,
  input  logic       dma_dread_i,
  output logic       irq_o,
  output logic       start_o,
  output logic       scan_o,
  output logic [3:0] chan_o
);

  logic       flag_q;
  logic       armed_q;
  logic [6:0] ctl_q;

  // set event: any done pulse in single mode, only the last one in scan mode
  wire set_ev = conv_done_i && (!ctl_q[4] || conv_last_i);
  wire sw_clr = bus_wr_i && !bus_wdata_i[7] && armed_q;
  wire flag_d = set_ev || (flag_q && !(sw_clr || dma_dread_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      ctl_q   <= '0;
    end else if (stby_i) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      ctl_q   <= '0;
    end else begin
      flag_q <= flag_d;
      if (bus_wr_i) ctl_q <= bus_wdata_i[6:0];
      if ((flag_q && !flag_d) || bus_wr_i) armed_q <= 1'b0;
      else if (bus_rd_i && flag_q)         armed_q <= 1'b1;
    end
  end

  assign bus_rdata_o = {flag_q, ctl_q};
  assign irq_o       = flag_q & ctl_q[6];
  assign start_o     = ctl_q[5];
  assign scan_o      = ctl_q[4];
  assign chan_o      = ctl_q[3:0];

  assert_stby_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stby_i |=> (bus_rdata_o == 8'h00 && !irq_o));

  assert_ctl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && !stby_i) |=> (bus_rdata_o[6:0] == $past(bus_wdata_i[6:0]) &&
                               chan_o == $past(bus_wdata_i[3:0])));

  assert_one_no_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_wdata_i[7] && flag_q && !dma_dread_i && !stby_i) |=> flag_q);

  assert_unarmed_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && !bus_wdata_i[7] && !armed_q && !dma_dread_i && !conv_done_i && !stby_i)
      |=> $stable(bus_rdata_o[7]));

  assert_dma_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_dread_i && !conv_done_i && !stby_i) |=> !bus_rdata_o[7]);

  assert_scan_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_o && conv_done_i && !conv_last_i && !flag_q && !stby_i) |=> !bus_rdata_o[7]);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done_i && (!scan_o || conv_last_i) && !stby_i) |=> bus_rdata_o[7]);

endmodule

// File: tb/adc_ctl_reg_bench.sv
module adc_ctl_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stby_i = 1'b0, bus_rd_i = 1'b0, bus_wr_i = 1'b0;
  logic [7:0] bus_wdata_i = 8'h00;
  logic       conv_done_i = 1'b0, conv_last_i = 1'b0, dma_dread_i = 1'b0;
  logic [7:0] bus_rdata_o;
  logic       irq_o, start_o, scan_o;
  logic [3:0] chan_o;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic       irq;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  adc_ctl_reg u_adc_ctl_reg (
    .clk(clk), .rst_n(rst_n), .stby_i(stby_i),
    .bus_rd_i(bus_rd_i), .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .conv_done_i(conv_done_i), .conv_last_i(conv_last_i),
    .dma_dread_i(dma_dread_i), .irq_o(irq_o), .start_o(start_o),
    .scan_o(scan_o), .chan_o(chan_o));

  // monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [14:0] act, exp;
      it  = sb_q.pop_front();
      act = {irq_o, start_o, scan_o, chan_o, bus_rdata_o};
      // R2 field positions: start=bit5, scan=bit4, chan=bits3..0; R9 irq=flag&bit6
      exp = {it.irq, it.rd[5], it.rd[4], it.rd[3:0], it.rd};
      checks++;
      if (act !== exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, exp);
      end
    end
  end

  task automatic expect_now(string tag, logic [7:0] rd);
    item_t it;
    it.tag = tag; it.rd = rd; it.irq = rd[7] & rd[6];
    sb_q.push_back(it);
  endtask

  task automatic drive(logic rd, logic wr, logic [7:0] wd, logic dn, logic ls,
                       logic dma, logic sb);
    @(posedge clk); #1;
    bus_rd_i = rd; bus_wr_i = wr; bus_wdata_i = wd;
    conv_done_i = dn; conv_last_i = ls; dma_dread_i = dma; stby_i = sb;
  endtask

  task automatic idle_chk(string tag, logic [7:0] rd);
    drive(0, 0, 8'h00, 0, 0, 0, 0);
    expect_now(tag, rd);
  endtask

  task automatic wr(logic [7:0] d);   drive(0, 1, d, 0, 0, 0, 0); endtask
  task automatic rdr();               drive(1, 0, 8'h00, 0, 0, 0, 0); endtask
  task automatic done(logic last);    drive(0, 0, 8'h00, 1, last, 0, 0); endtask
  task automatic dma();               drive(0, 0, 8'h00, 0, 0, 1, 0); endtask

  initial begin
    fork
      begin
        #200000;
        if (!done_flag) begin
          fails++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
          $finish;
        end
      end
    join_none

    #20 rst_n = 1'b1;
    idle_chk("R1 reset", 8'h00);

    wr(8'h60);         idle_chk("R2 write ctl", 8'h60);
    wr(8'hE0);         idle_chk("R3 write one to flag", 8'h60);
    done(0);           idle_chk("R7 single set / R9 irq", 8'hE0);
    wr(8'h60);         idle_chk("R5 unarmed write zero", 8'hE0);
    rdr(); expect_now("R12 live read", 8'hE0);
    wr(8'h60);         idle_chk("R4 armed clear", 8'h60);

    done(1);           idle_chk("R7 single set with last", 8'hE0);
    rdr();
    wr(8'hE0);         idle_chk("R3 armed write one", 8'hE0);
    wr(8'h60);         idle_chk("R11 arm consumed", 8'hE0);
    rdr();
    wr(8'h20);         idle_chk("R4 clear and disable", 8'h20);
    done(0);           idle_chk("R9 irq masked", 8'hA0);
    dma();             idle_chk("R6 dma clear", 8'h20);

    wr(8'h53);         idle_chk("R2 scan setup", 8'h53);
    done(0);           idle_chk("R8 scan not last 1", 8'h53);
    done(0);           idle_chk("R8 scan not last 2", 8'h53);
    done(1);           idle_chk("R8 scan last", 8'hD3);
    rdr();
    drive(0, 1, 8'h53, 1, 1, 0, 0); idle_chk("R10 set beats sw clear", 8'hD3);
    drive(0, 0, 8'h00, 1, 1, 1, 0); idle_chk("R10 set beats dma", 8'hD3);
    rdr();
    dma();             idle_chk("R6 dma clear scan", 8'h53);
    done(1);           idle_chk("R8 scan set again", 8'hD3);
    wr(8'h53);         idle_chk("R11 arm dropped on clear", 8'hD3);
    rdr();
    wr(8'h53);         idle_chk("R4 scan clear", 8'h53);

    wr(8'h7F);         idle_chk("R2 all ctl bits", 8'h7F);
    done(1);           idle_chk("R9 irq on", 8'hFF);
    drive(0, 0, 8'h00, 0, 0, 0, 1); idle_chk("R1 standby clear", 8'h00);

    idle_chk("R1 settled", 8'h00);
    @(negedge clk); #1;
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule